// File: doc/BRIEF.md
# Dual Serial Shift Register with Selectable Input

The block holds two independent serial shift lanes, A and B. Each lane is `STAGES` bits deep (eight by default). A 2-to-1 selector sits in front of each lane's serial input. One select line, shared by both lanes, chooses between the lane's two data pins. Each lane offers its last stage as a true output and as a complemented output.

A lane advances on the rising edge of its effective shift clock. That clock is the logical OR of a shift clock common to both lanes and a shift clock that belongs to that lane alone. Holding either input of an OR pair high therefore acts as a shift inhibit for that lane.

The block is synchronous to a free-running system clock. The shift clock inputs, the select line and the data pins are registered on that clock. Each OR clock is edge-detected into a shift enable that lasts one cycle. An active-low master reset clears both lanes asynchronously. Its release is synchronised to the system clock.

Top module: `dual_mux_shifter`

## Requirements
- R1: While `rst_ni` is low, every `q_o` bit is 0 and every `qn_o` bit is 1. This holds whatever the other inputs do, and the outputs clear as soon as reset falls, without waiting for a system clock edge.
- R2: The bit shifted into lane i is `d0_i[i]` when `sel_i` is 0 and `d1_i[i]` when `sel_i` is 1. All inputs are taken as registered at the same system clock edge that registered the clock rise. `sel_i` is shared by both lanes.
- R3: Lane i shifts exactly once when `clk_com_i | clk_sep_i[i]` goes from 0 to 1. The change appears on `q_o[i]` after the second rising system clock edge that follows the input change.
- R4: A rise of one input of lane i's OR pair while the other input is already high causes no shift. A fall of one input while the other stays high causes no shift either. A new shift needs both inputs low first and then a rise.
- R5: A rise on `clk_sep_i[i]` alone shifts only lane i. A rise on `clk_com_i` with both separate clocks low shifts both lanes.
- R6: Each shift moves stage k into stage k+1 and loads the selected serial bit into stage 0. A bit applied at the serial input therefore reaches `q_o[i]` after `STAGES` shifts.
- R7: `qn_o[i]` is always the inverse of `q_o[i]`.
- R8: A shift clock input that is already high when reset is released causes no shift. Only a rise that happens after release counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low master reset, asynchronous assert |
| clk_com_i | input | 1 | Shift clock common to all lanes |
| clk_sep_i | input | NUM_LANES | Per-lane shift clock, ORed with the common one |
| sel_i | input | 1 | Serial input select shared by all lanes (0 picks d0, 1 picks d1) |
| d0_i | input | NUM_LANES | Per-lane serial data, chosen when sel_i is 0 |
| d1_i | input | NUM_LANES | Per-lane serial data, chosen when sel_i is 1 |
| q_o | output | NUM_LANES | Last stage of each lane |
| qn_o | output | NUM_LANES | Complement of the last stage of each lane |

## Verification
The hardest case to reach from the ports is a shift that should not happen. A spurious shift is visible on `q_o` only when the last two stages differ, so the check needs a lane preloaded with alternating bits. The stimulus fills lane A with a 1010 pattern through its separate clock. It then overlaps the common clock with that held separate clock, so any wrong shift toggles the output. The reset-release case uses a similar trick. Both clock inputs are held high across release with data at 1, and then exactly one edge fewer than the lane depth is applied with data at 0. A spurious shift at release would surface as a 1 on the last stage.

// File: rtl/dms_pkg.sv
package dms_pkg;

  typedef enum logic {
    ARM_WAIT  = 1'b0,
    ARM_READY = 1'b1
  } arm_e;

  function automatic logic pick_serial(input logic sel, input logic d_lo, input logic d_hi);
    return sel ? d_hi : d_lo;
  endfunction

endpackage

// File: rtl/dms_rst_sync.sv
module dms_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/dms_edge_det.sv
module dms_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic com_raw_i,
  input  logic com_q_i,
  input  logic sep_raw_i,
  output logic shift_en_o
);
  import dms_pkg::*;

  logic sep_q, sep_d;
  logic prev_q, prev_d;
  arm_e arm_q, arm_d;
  logic or_now;

  always_comb begin
    or_now = com_q_i | sep_q;
    sep_d  = sep_raw_i;
    arm_d  = ARM_READY;
    // Before arming, load the history with the level being sampled so that
    // a clock already high at reset release never looks like a rise.
    if (arm_q == ARM_READY) begin
      prev_d = or_now;
    end else begin
      prev_d = com_raw_i | sep_raw_i;
    end
    shift_en_o = (arm_q == ARM_READY) && or_now && !prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sep_q  <= 1'b0;
      prev_q <= 1'b0;
      arm_q  <= ARM_WAIT;
    end else begin
      sep_q  <= sep_d;
      prev_q <= prev_d;
      arm_q  <= arm_d;
    end
  end

endmodule

// File: rtl/dms_shift_lane.sv
module dms_shift_lane #(
  parameter int STAGES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_en_i,
  input  logic sel_q_i,
  input  logic d0_i,
  input  logic d1_i,
  output logic last_o,
  output logic pre_last_o
);
  import dms_pkg::*;

  localparam int LastIdx = STAGES - 1;

  logic [STAGES-1:0] stage_q, stage_d;
  logic d0_q, d0_d;
  logic d1_q, d1_d;
  logic serial_bit;

  always_comb begin
    d0_d       = d0_i;
    d1_d       = d1_i;
    serial_bit = pick_serial(sel_q_i, d0_q, d1_q);
    stage_d    = stage_q;
    if (shift_en_i) begin
      stage_d = {stage_q[STAGES-2:0], serial_bit};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d0_q    <= 1'b0;
      d1_q    <= 1'b0;
      stage_q <= '0;
    end else begin
      d0_q    <= d0_d;
      d1_q    <= d1_d;
      stage_q <= stage_d;
    end
  end

  assign last_o     = stage_q[LastIdx];
  assign pre_last_o = stage_q[LastIdx-1];

endmodule

// File: rtl/dual_mux_shifter.sv
module dual_mux_shifter #(
  parameter int NUM_LANES   = 2,
  parameter int STAGES      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clk_com_i,
  input  logic [NUM_LANES-1:0] clk_sep_i,
  input  logic                 sel_i,
  input  logic [NUM_LANES-1:0] d0_i,
  input  logic [NUM_LANES-1:0] d1_i,
  output logic [NUM_LANES-1:0] q_o,
  output logic [NUM_LANES-1:0] qn_o
);

  logic                 rst_sync_n;
  logic                 com_q, com_d;
  logic                 sel_q, sel_d;
  logic [NUM_LANES-1:0] shift_en;
  logic [NUM_LANES-1:0] last;
  logic [NUM_LANES-1:0] pre_last;

  dms_rst_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  always_comb begin
    com_d = clk_com_i;
    sel_d = sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      com_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      com_q <= com_d;
      sel_q <= sel_d;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dms_edge_det u_edge (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .com_raw_i (clk_com_i),
      .com_q_i   (com_q),
      .sep_raw_i (clk_sep_i[g]),
      .shift_en_o(shift_en[g])
    );

    dms_shift_lane #(
      .STAGES(STAGES)
    ) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .shift_en_i(shift_en[g]),
      .sel_q_i   (sel_q),
      .d0_i      (d0_i[g]),
      .d1_i      (d1_i[g]),
      .last_o    (last[g]),
      .pre_last_o(pre_last[g])
    );

    assign q_o[g]  = last[g];
    assign qn_o[g] = ~last[g];
  end

endmodule

// File: rtl/dms_checker.sv
module dms_checker #(
  parameter int NUM_LANES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clk_com,
  input logic [NUM_LANES-1:0] clk_sep,
  input logic [NUM_LANES-1:0] shift_en,
  input logic [NUM_LANES-1:0] pre_last,
  input logic [NUM_LANES-1:0] q,
  input logic [NUM_LANES-1:0] qn
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (q == '0 && qn == '1)
        else $error("lane outputs not cleared during reset");
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
    // R3: an enable only follows a 0 -> 1 change of the raw OR clock pair
    assert_enable_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en[g] |-> ($past(clk_com | clk_sep[g], 1) && !$past(clk_com | clk_sep[g], 2)));

    // R4: one rise yields a single one-cycle enable
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en[g] |=> !shift_en[g]);

    // R4: without an enable the last stage holds
    assert_hold_without_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en[g] |=> $stable(q[g]));

    // R6: a shift moves the penultimate stage into the last stage
    assert_stage_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en[g] |=> (q[g] == $past(pre_last[g])));
  end

endmodule

bind dual_mux_shifter dms_checker #(
  .NUM_LANES(NUM_LANES)
) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .clk_com (clk_com_i),
  .clk_sep (clk_sep_i),
  .shift_en(shift_en),
  .pre_last(pre_last),
  .q       (q_o),
  .qn      (qn_o)
);

// File: tb/sim_dual_mux_shifter.sv
module sim_dual_mux_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 2;
  localparam int DEPTH      = 8;

  logic             clk;
  logic             rst_n;
  logic             clk_com;
  logic [LANES-1:0] clk_sep;
  logic             sel;
  logic [LANES-1:0] d0;
  logic [LANES-1:0] d1;
  logic [LANES-1:0] q;
  logic [LANES-1:0] qn;

  logic [DEPTH-1:0] mdl [LANES];
  int checks;
  int errors;

  dual_mux_shifter #(
    .NUM_LANES(LANES),
    .STAGES   (DEPTH)
  ) u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .clk_com_i(clk_com),
    .clk_sep_i(clk_sep),
    .sel_i    (sel),
    .d0_i     (d0),
    .d1_i     (d1),
    .q_o      (q),
    .qn_o     (qn)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    for (int l = 0; l < LANES; l++) begin
      check_bit(tag, q[l], mdl[l][DEPTH-1]);
      check_bit({tag, " R7 complement"}, qn[l], ~mdl[l][DEPTH-1]);
    end
  endtask

  task automatic shift_model(input int l);
    logic b;
    b = sel ? d1[l] : d0[l];
    mdl[l] = {mdl[l][DEPTH-2:0], b};
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lane_bit(input int l, input logic b);
    if (sel) begin
      d1[l] = b;
      d0[l] = ~b;
    end else begin
      d0[l] = b;
      d1[l] = ~b;
    end
  endtask

  // raise the chosen clock inputs, check, then drop all of them
  task automatic pulse(input logic com, input logic [LANES-1:0] sep, input string tag);
    clk_com = com;
    clk_sep = sep;
    wait_neg(2);
    for (int l = 0; l < LANES; l++) begin
      if (com || sep[l]) shift_model(l);
    end
    check_all(tag);
    clk_com = 1'b0;
    clk_sep = '0;
    wait_neg(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    clk_com = 1'b0;
    clk_sep = '0;
    sel     = 1'b0;
    d0      = '1;
    d1      = '1;
    for (int l = 0; l < LANES; l++) mdl[l] = '0;
    wait_neg(4);
    check_all("R1 reset state");
    rst_n = 1'b1;
    wait_neg(6);
    check_all("R1 after release");

    // R2 R3 R5 R6: sweep every byte pattern through the lanes
    for (int pat = 0; pat < 256; pat++) begin
      for (int k = 0; k < DEPTH; k++) begin
        logic [7:0] p;
        int which;
        p   = pat[7:0];
        sel = p[k % 8] ^ k[0];
        set_lane_bit(0, p[k]);
        set_lane_bit(1, p[DEPTH-1-k] ^ p[0]);
        which = (pat + k) % 3;
        if (which == 0)      pulse(1'b1, 2'b00, "R2 R3 R6 common shift");
        else if (which == 1) pulse(1'b0, 2'b01, "R5 separate lane A");
        else                 pulse(1'b0, 2'b10, "R5 separate lane B");
      end
    end

    // R4: preload lane A with alternating bits so any extra shift toggles q
    for (int k = 0; k < DEPTH; k++) begin
      sel = k[1];
      set_lane_bit(0, k[0] ? 1'b0 : 1'b1);
      set_lane_bit(1, k[0]);
      pulse(1'b0, 2'b01, "R4 preload");
    end
    sel = 1'b0;
    set_lane_bit(0, mdl[0][DEPTH-1]);
    set_lane_bit(1, ~mdl[1][DEPTH-1]);
    clk_sep = 2'b01;
    wait_neg(2);
    shift_model(0);
    check_all("R4 separate rise");
    clk_com = 1'b1;
    wait_neg(2);
    shift_model(1);
    check_all("R4 common rise while separate high");
    clk_sep = 2'b00;
    wait_neg(2);
    check_all("R4 separate fall while common high");
    clk_sep = 2'b01;
    wait_neg(2);
    check_all("R4 separate re-rise while common high");
    clk_sep = 2'b00;
    clk_com = 1'b0;
    wait_neg(2);
    check_all("R4 both low");
    clk_sep = 2'b01;
    wait_neg(2);
    shift_model(0);
    check_all("R4 shift after both low");
    clk_sep = 2'b00;
    wait_neg(2);

    // R1: fill with ones, then reset away from a clock edge
    sel = 1'b1;
    d1  = '1;
    d0  = '0;
    for (int k = 0; k < DEPTH; k++) pulse(1'b1, 2'b00, "R1 fill ones");
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    for (int l = 0; l < LANES; l++) mdl[l] = '0;
    check_all("R1 asynchronous clear");
    wait_neg(3);
    check_all("R1 held in reset with ones at input");

    // R8: clocks high through release, data 1, then DEPTH-1 edges of zeros
    clk_com = 1'b1;
    clk_sep = '1;
    wait_neg(1);
    rst_n = 1'b1;
    wait_neg(6);
    check_all("R8 after release with clocks high");
    clk_com = 1'b0;
    clk_sep = '0;
    wait_neg(2);
    d0 = '0;
    d1 = '0;
    for (int k = 0; k < DEPTH - 1; k++) pulse(1'b1, 2'b00, "R8 no shift at release");
    check_all("R8 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule